// File: doc/BRIEF.md
# Addressed Serial Control and Status Port

This block is the slave side of a three-wire serial link with a separate data-out line. A controller selects the block with chip enable and moves bits with a serial clock. While chip enable is low, the controller shifts in an 8-bit address. Raising chip enable then starts the data phase. That phase either writes one of two 32-bit control words or reads back a 32-bit status word. The status word holds the input-pin levels and a 20-bit counter value. A written word is gathered in a shift register. It reaches the parallel control outputs only when chip enable falls after exactly 32 data bits. A wrong bit count or an unknown address leaves both control words untouched.

When no read is running, the data-out line acts as an active-low event line. Fields of control word 2 select its source: a PLL unlock indication, a count-finished indication, the level of one of two input pins, or a sticky "input 1 has changed" event. The serial pins and the input pins are asynchronous. They pass through synchronizers into the block clock domain, so the serial clock must be much slower than the block clock.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset both control words read 0x0000_0000, which means all ports are inputs, the 4.5 MHz option is chosen, the timebase is off and the test bits are clear. The data-out line is 1.
- R2: While chip enable is low, address bits are taken on rising serial-clock edges. The last 8 bits taken, read with the first-received bit leftmost, select the transaction: 00010010 writes word 1, 10010010 writes word 2, and 01010010 reads status.
- R3: While chip enable is high, data bits are taken on rising serial-clock edges, and the first bit received becomes bit 0 of the word. The word is copied to its control register on the fall of chip enable only if exactly 32 data bits were taken.
- R4: A control word changes only at the end of a complete write addressed to it; the other word keeps its value.
- R5: An address that matches none of the three codes makes the block ignore the whole data phase, and both control words keep their values.
- R6: A read sends 32 bits, and the word is captured when chip enable rises. The order on the line is I1..I7, then five 0 bits, then counter bits C19..C0. The first bit is present before the first rising serial-clock edge, and each later bit appears after a falling edge. Pin changes after capture do not alter the word.
- R7: I6 reads 0 when control word 2 bit 5 is set, and I7 reads 0 when bit 6 is set; these bits mark the pins as counter inputs.
- R8: While chip enable is high during a write or an unknown transaction, data-out is 1. When chip enable falls, data-out goes back to the flag line.
- R9: Outside a transaction, control word 2 bits [2:0] select the flag source, with bit 2 = ULD, bit 1 = DT1 and bit 0 = DT0. 000 gives low when unlocked. 010 and 110 give low when counting is done. 011 and 111 give the input state. 001, 100 and 101 give 1.
- R10: The input state is chosen by control word 2 bits [4:3]. 00 gives 1, 01 gives the level of input 1, and 10 gives the level of input 2. 11 gives low once input 1 has changed since the last rise of chip enable. A change seen in the same cycle as that rise is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable from the controller |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, 0 = pull low, 1 = released |
| in_pins_i | input | 7 | Input pin levels I1..I7 (bit 0 = I1) |
| cnt_value_i | input | 20 | Counter value for the status word |
| unlock_i | input | 1 | 1 = PLL unlocked |
| count_done_i | input | 1 | 1 = counter measurement finished |
| ctrl1_o | output | 32 | Control word 1 |
| ctrl2_o | output | 32 | Control word 2 |

## Verification
A rise of chip enable clears the sticky input-1 change flag, and a toggle of input 1 sets it. Both can land in the same clock cycle. The bench provokes this by moving chip enable and input 1 on the same block-clock edge. Both go through the same synchronizer depth, so they reach the flag logic together. With the flag source set to the change event, data-out must read low after that transaction ends, which shows the set won. A transaction without a toggle must leave data-out high.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 20;
  localparam int NPIN   = 7;
  localparam int PAD_W  = WORD_W - NPIN - CNT_W;

  localparam logic [ADDR_W-1:0] ADDR_WR1 = 8'b0001_0010;
  localparam logic [ADDR_W-1:0] ADDR_WR2 = 8'b1001_0010;
  localparam logic [ADDR_W-1:0] ADDR_RD  = 8'b0101_0010;

  // control word 2 field positions
  localparam int FSEL_LSB  = 0;
  localparam int ISEL_LSB  = 3;
  localparam int P6CTR_BIT = 5;
  localparam int P7CTR_BIT = 6;

  typedef enum logic [1:0] {MODE_NONE, MODE_WR1, MODE_WR2, MODE_RD} scp_mode_e;

  function automatic scp_mode_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_WR1: return MODE_WR1;
      ADDR_WR2: return MODE_WR2;
      ADDR_RD:  return MODE_RD;
      default:  return MODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scp_rx.sv
module scp_rx import scp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              ce_rise,
  input  logic              ce_fall,
  input  logic              sck_rise,
  input  logic              sdi_s,
  output scp_mode_e         mode_o,
  output logic [WORD_W-1:0] word_o,
  output logic              wr1_stb_o,
  output logic              wr2_stb_o,
  output logic              rd_start_o
);
  localparam int CB = $clog2(WORD_W + 2);
  localparam logic [CB-1:0] FULL = CB'(WORD_W);
  localparam logic [CB-1:0] OVER = CB'(WORD_W + 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [CB-1:0]     cnt_q, cnt_d;
  scp_mode_e         mode_q, mode_d;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (ce_fall) begin
      addr_d = '0;
      cnt_d  = '0;
      mode_d = MODE_NONE;
    end else if (ce_rise) begin
      cnt_d  = '0;
      mode_d = decode_addr(addr_q);
    end else if (sck_rise) begin
      if (ce_s) begin
        data_d = {sdi_s, data_q[WORD_W-1:1]};
        cnt_d  = (cnt_q == OVER) ? cnt_q : cnt_q + 1'b1;
      end else begin
        addr_d = {addr_q[ADDR_W-2:0], sdi_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      mode_q <= MODE_NONE;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign mode_o     = mode_q;
  assign word_o     = data_q;
  assign wr1_stb_o  = ce_fall && (mode_q == MODE_WR1) && (cnt_q == FULL);
  assign wr2_stb_o  = ce_fall && (mode_q == MODE_WR2) && (cnt_q == FULL);
  assign rd_start_o = ce_rise && (addr_q == ADDR_RD);
endmodule

// File: rtl/scp_tx.sv
module scp_tx import scp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_i) sr_d = word_i;
    else if (shift_i) sr_d = {sr_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else sr_q <= sr_d;
  end

  assign bit_o = sr_q[WORD_W-1];
endmodule

// File: rtl/scp_flag.sv
module scp_flag (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fsel_i,
  input  logic [1:0] isel_i,
  input  logic       unlock_i,
  input  logic       done_i,
  input  logic       pin1_i,
  input  logic       pin2_i,
  input  logic       pin1_chg_i,
  input  logic       clr_i,
  output logic       flag_o
);
  logic chg_q, chg_d, in_state;

  always_comb begin
    chg_d = chg_q;
    if (pin1_chg_i) chg_d = 1'b1;   // set beats clear
    else if (clr_i) chg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else chg_q <= chg_d;
  end

  always_comb begin
    case (isel_i)
      2'b00:   in_state = 1'b1;
      2'b01:   in_state = pin1_i;
      2'b10:   in_state = pin2_i;
      default: in_state = ~chg_q;
    endcase
    case (fsel_i)
      3'b000:         flag_o = ~unlock_i;
      3'b010, 3'b110: flag_o = ~done_i;
      3'b011, 3'b111: flag_o = in_state;
      default:        flag_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port import scp_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [NPIN-1:0]   in_pins_i,
  input  logic [CNT_W-1:0]  cnt_value_i,
  input  logic              unlock_i,
  input  logic              count_done_i,
  output logic [WORD_W-1:0] ctrl1_o,
  output logic [WORD_W-1:0] ctrl2_o
);
  localparam int SW = NPIN + 3;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SW-1:0]   sync_q;
  logic            ce_s, sck_s, sdi_s;
  logic [NPIN-1:0] in_s;

  scp_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d_i({in_pins_i, sdi_i, sck_i, ce_i}), .q_o(sync_q)
  );
  assign ce_s  = sync_q[0];
  assign sck_s = sync_q[1];
  assign sdi_s = sync_q[2];
  assign in_s  = sync_q[SW-1:3];

  logic ce_d, sck_d, p1_d;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ce_d  <= 1'b0;
      sck_d <= 1'b0;
      p1_d  <= 1'b0;
    end else begin
      ce_d  <= ce_s;
      sck_d <= sck_s;
      p1_d  <= in_s[0];
    end
  end

  logic ce_rise, ce_fall, sck_rise, sck_fall, p1_chg;
  assign ce_rise  = ce_s & ~ce_d;
  assign ce_fall  = ~ce_s & ce_d;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign p1_chg   = in_s[0] ^ p1_d;

  scp_mode_e         mode;
  logic [WORD_W-1:0] rx_word;
  logic              wr1_stb, wr2_stb, rd_start;

  scp_rx u_rx (
    .clk(clk), .rst_n(rst_int_n), .ce_s(ce_s), .ce_rise(ce_rise),
    .ce_fall(ce_fall), .sck_rise(sck_rise), .sdi_s(sdi_s),
    .mode_o(mode), .word_o(rx_word), .wr1_stb_o(wr1_stb),
    .wr2_stb_o(wr2_stb), .rd_start_o(rd_start)
  );

  // status word: I1 first, then pad, then counter MSB first
  logic [NPIN-1:0]   in_eff;
  logic [WORD_W-1:0] status_word;
  always_comb begin
    in_eff = in_s;
    if (ctrl2_o[P6CTR_BIT]) in_eff[5] = 1'b0;
    if (ctrl2_o[P7CTR_BIT]) in_eff[6] = 1'b0;
  end

  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_pin
      assign status_word[WORD_W-1-i] = in_eff[i];
    end
  endgenerate
  assign status_word[CNT_W+PAD_W-1:CNT_W] = '0;
  assign status_word[CNT_W-1:0]           = cnt_value_i;

  logic tx_bit;
  scp_tx u_tx (
    .clk(clk), .rst_n(rst_int_n), .load_i(rd_start),
    .shift_i(sck_fall && ce_s && (mode == MODE_RD)),
    .word_i(status_word), .bit_o(tx_bit)
  );

  logic flag;
  scp_flag u_flag (
    .clk(clk), .rst_n(rst_int_n),
    .fsel_i(ctrl2_o[FSEL_LSB +: 3]), .isel_i(ctrl2_o[ISEL_LSB +: 2]),
    .unlock_i(unlock_i), .done_i(count_done_i),
    .pin1_i(in_s[0]), .pin2_i(in_s[1]),
    .pin1_chg_i(p1_chg), .clr_i(ce_rise), .flag_o(flag)
  );

  logic [WORD_W-1:0] ctrl1_q, ctrl2_q;
  logic              sdo_q, sdo_d;

  always_comb begin
    if (ce_s) sdo_d = (mode == MODE_RD) ? tx_bit : 1'b1;
    else      sdo_d = flag;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl1_q <= '0;
      ctrl2_q <= '0;
      sdo_q   <= 1'b1;
    end else begin
      if (wr1_stb) ctrl1_q <= rx_word;
      if (wr2_stb) ctrl2_q <= rx_word;
      sdo_q <= sdo_d;
    end
  end

  assign ctrl1_o = ctrl1_q;
  assign ctrl2_o = ctrl2_q;
  assign sdo_o   = sdo_q;
endmodule

// File: rtl/scp_checker.sv
module scp_checker import scp_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_s,
  input logic              ce_rise,
  input logic              ce_fall,
  input scp_mode_e         mode,
  input logic              sdo,
  input logic [WORD_W-1:0] ctrl1,
  input logic [WORD_W-1:0] ctrl2
);
  AST_CTRL_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> ($stable(ctrl1) && $stable(ctrl2))) else $error("ctrl moved"); // R4

  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && mode == MODE_NONE) |=> ($stable(ctrl1) && $stable(ctrl2))) else $error("bad addr wrote"); // R5

  AST_SDO_OPEN_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && mode != MODE_RD) |=> sdo) else $error("sdo low in non-read"); // R8

  AST_SDO_OPEN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> sdo) else $error("sdo low at start"); // R8

  AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> (mode == MODE_NONE)) else $error("mode kept"); // R2
endmodule

bind serial_ctrl_port scp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .ce_rise(ce_rise),
  .ce_fall(ce_fall), .mode(mode), .sdo(sdo_o),
  .ctrl1(ctrl1_o), .ctrl2(ctrl2_o)
);

// File: tb/tb_serial_ctrl_port.sv
`timescale 1ns/1ps
module tb_serial_ctrl_port;
  logic clk = 1'b0;
  logic rst_n, ce, sck, sdi, sdo, unlock, done;
  logic [6:0]  pins;
  logic [19:0] cnt;
  logic [31:0] c1, c2;
  int  n_tests = 0, n_fail = 0;
  bit  finished = 0;
  bit  tog_at_rise = 0;
  bit  mid_hi;

  always #2.5 clk = ~clk;

  serial_ctrl_port dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .in_pins_i(pins), .cnt_value_i(cnt), .unlock_i(unlock),
    .count_done_i(done), .ctrl1_o(c1), .ctrl2_o(c2)
  );

  localparam logic [7:0] A_W1 = 8'b0001_0010;
  localparam logic [7:0] A_W2 = 8'b1001_0010;
  localparam logic [7:0] A_RD = 8'b0101_0010;
  localparam logic [7:0] A_BAD = 8'b0001_0011;

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdi = b; wclk(4); sck = 1'b1; wclk(8); sck = 1'b0; wclk(4);
  endtask

  task automatic send_addr(input logic [7:0] a);
    ce = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
    wclk(4);
  endtask

  task automatic write_word(input logic [7:0] a, input logic [31:0] d, input int nbits);
    send_addr(a);
    ce = 1'b1;
    if (tog_at_rise) pins[0] = ~pins[0];
    wclk(8);
    mid_hi = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      send_bit(d[i % 32]);
      if (sdo !== 1'b1) mid_hi = 1'b0;
    end
    wclk(4); ce = 1'b0; wclk(12);
  endtask

  task automatic read_word(output logic [31:0] w, input int tog_at);
    send_addr(A_RD);
    ce = 1'b1; wclk(8);
    for (int i = 0; i < 32; i++) begin
      sck = 1'b1; wclk(6);
      w[31-i] = sdo;
      if (i == tog_at) pins = ~pins;
      wclk(2); sck = 1'b0; wclk(8);
    end
    wclk(4); ce = 1'b0; wclk(12);
  endtask

  function automatic logic [31:0] exp_status(input logic [6:0] p, input logic [19:0] c,
                                             input logic m6, input logic m7);
    logic [31:0] w = '0;
    logic [6:0] q = p;
    if (m6) q[5] = 1'b0;
    if (m7) q[6] = 1'b0;
    for (int i = 0; i < 7; i++) w[31-i] = q[i];
    w[19:0] = c;
    return w;
  endfunction

  task automatic t_reset();
    chk("R1 ctrl1", c1, 32'h0);
    chk("R1 ctrl2", c2, 32'h0);
    chk("R1 sdo", {31'h0, sdo}, 32'h1);
  endtask

  task automatic t_writes();
    write_word(A_W1, 32'hA5C3_1E07, 32);
    chk("R2 R3 ctrl1 written", c1, 32'hA5C3_1E07);
    chk("R4 ctrl2 untouched", c2, 32'h0);
    write_word(A_W2, 32'h1234_5601, 32);
    chk("R2 ctrl2 written", c2, 32'h1234_5601);
    chk("R4 ctrl1 untouched", c1, 32'hA5C3_1E07);
    write_word(A_W1, 32'h0F0F_0F0F, 31);
    chk("R3 short write ignored", c1, 32'hA5C3_1E07);
    write_word(A_W1, 32'h0F0F_0F0F, 33);
    chk("R3 long write ignored", c1, 32'hA5C3_1E07);
  endtask

  task automatic t_bad_addr();
    write_word(A_BAD, 32'hFFFF_FFFF, 32);
    chk("R5 ctrl1 kept", c1, 32'hA5C3_1E07);
    chk("R5 ctrl2 kept", c2, 32'h1234_5601);
  endtask

  task automatic t_sdo_in_write();
    write_word(A_W2, 32'h0000_0000, 32);   // flag = unlock
    unlock = 1'b1; wclk(8);
    chk("R9 unlock low", {31'h0, sdo}, 32'h0);
    write_word(A_BAD, 32'h0, 32);
    chk("R8 sdo high in unknown txn", {31'h0, mid_hi}, 32'h1);
    chk("R8 flag back after ce fall", {31'h0, sdo}, 32'h0);
    write_word(A_W2, 32'h0000_0000, 32);
    chk("R8 sdo high in write", {31'h0, mid_hi}, 32'h1);
    unlock = 1'b0; wclk(8);
  endtask

  task automatic t_read();
    logic [31:0] w;
    pins = 7'b1010011; cnt = 20'hABCDE;
    read_word(w, -1);
    chk("R6 status word", w, exp_status(7'b1010011, 20'hABCDE, 0, 0));
    pins = 7'b0110101; cnt = 20'h13579;
    read_word(w, 2);
    chk("R6 captured at entry", w, exp_status(7'b0110101, 20'h13579, 0, 0));
    write_word(A_W2, 32'h0000_0060, 32);
    pins = 7'h7F; cnt = 20'hFFFFF;
    read_word(w, -1);
    chk("R7 I6 I7 masked", w, exp_status(7'h7F, 20'hFFFFF, 1, 1));
    write_word(A_W2, 32'h0000_0020, 32);
    read_word(w, -1);
    chk("R7 only I6 masked", w, exp_status(7'h7F, 20'hFFFFF, 1, 0));
  endtask

  task automatic t_flag_sel();
    logic e;
    pins = 7'h0;
    for (int s = 0; s < 8; s++) begin
      write_word(A_W2, 32'h0000_0008 | s, 32);
      unlock = 1'b1; done = 1'b0; pins[0] = 1'b0; wclk(8);
      case (s)
        0: e = 1'b0; 2, 6: e = 1'b1; 3, 7: e = 1'b0; default: e = 1'b1;
      endcase
      chk($sformatf("R9 sel %0d case A", s), {31'h0, sdo}, {31'h0, e});
      unlock = 1'b0; done = 1'b1; pins[0] = 1'b1; wclk(8);
      case (s)
        0: e = 1'b1; 2, 6: e = 1'b0; 3, 7: e = 1'b1; default: e = 1'b1;
      endcase
      chk($sformatf("R9 sel %0d case B", s), {31'h0, sdo}, {31'h0, e});
    end
    done = 1'b0;
  endtask

  task automatic t_in_state();
    pins = 7'b0000011;
    write_word(A_W2, 32'h0000_0003, 32);  // isel 00
    chk("R10 isel 00 open", {31'h0, sdo}, 32'h1);
    write_word(A_W2, 32'h0000_0013, 32);  // isel 10 -> pin2
    pins[1] = 1'b0; wclk(8);
    chk("R10 isel 10 pin2 low", {31'h0, sdo}, 32'h0);
    pins[1] = 1'b1; wclk(8);
    chk("R10 isel 10 pin2 high", {31'h0, sdo}, 32'h1);
    write_word(A_W2, 32'h0000_001B, 32);  // isel 11 change
    chk("R10 no change yet", {31'h0, sdo}, 32'h1);
    pins[0] = ~pins[0]; wclk(8);
    chk("R10 change pulls low", {31'h0, sdo}, 32'h0);
    pins[0] = ~pins[0]; wclk(8);
    chk("R10 change sticky", {31'h0, sdo}, 32'h0);
    write_word(A_BAD, 32'h0, 32);
    chk("R10 cleared by txn", {31'h0, sdo}, 32'h1);
    tog_at_rise = 1;
    write_word(A_BAD, 32'h0, 32);
    tog_at_rise = 0;
    chk("R10 change at ce rise kept", {31'h0, sdo}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; ce = 1'b0; sck = 1'b0; sdi = 1'b0;
    unlock = 1'b0; done = 1'b0; pins = '0; cnt = '0;
    wclk(5); rst_n = 1'b1; wclk(8);
    t_reset();
    t_writes();
    t_bad_addr();
    t_sdo_in_write();
    t_read();
    t_flag_sel();
    t_in_state();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule